// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block sits between a simple memory-mapped read port and the pins of a serial flash. When it owns the pins, each 32-bit bus read becomes one complete flash read burst: chip select falls, a read command byte and a configurable number of address bytes go out on a single output line, a configurable number of idle (dummy) clocks follow, and then four data bytes are collected on one, two or four lines. When the burst ends, chip select rises and the assembled word is returned with a one-cycle ready pulse.

A single 32-bit setup word describes the burst: the command byte, how many address bytes, how many dummy bytes plus extra dummy clocks, and how many data lines. A separate enable input decides who drives the pins. When it is low, a command-driven engine elsewhere on the chip drives them and this block passes those signals straight through. The bus side holds `bus_rd` high until it sees `bus_rdy`.

Top module: `mmap_flash_reader`

## Requirements
- R1: While reset is held and after it, `bus_rdy` is low, `mmap_owner` is low and every pin output equals its command-engine input.
- R2: When `mmap_owner` is low, `spi_sclk`, `spi_cs_n`, `spi_io_o` and `spi_io_oe` follow `cmd_sclk`, `cmd_cs_n`, `cmd_io_o` and `cmd_io_oe`. `mmap_owner` rises one cycle after `mmap_en` is set.
- R3: A read requested while `mmap_en` is low starts no burst and gives no ready. The request stays pending and is served once `mmap_en` is set.
- R4: The first 8 serial clocks of a burst carry `rd_setup[7:0]` most significant bit first on `spi_io_o[0]`, with `spi_io_oe` equal to 4'b0001. Outside the command and address clocks, `spi_io_oe` is 0 whenever the block owns the pins.
- R5: `rd_setup[9:8]` gives N, from 0 to 3 address bytes. The low 8*N bits of `bus_addr` follow the command most significant bit first on `spi_io_o[0]`. N=0 sends no address.
- R6: After the address come 8*`rd_setup[11:10]` + `rd_setup[28:24]` dummy clocks with all outputs released.
- R7: `rd_setup[13:12]` picks the data lines: 1 means two lines (`spi_io_i[1:0]`, 16 clocks), 3 means four lines (`spi_io_i[3:0]`, 8 clocks), and 0 or 2 means one line (`spi_io_i[1]`, 32 clocks).
- R8: Within each data clock the higher-numbered line carries the earlier bit. Each byte arrives most significant bit first. The first received byte lands in `bus_rdata[7:0]` and the fourth in `bus_rdata[31:24]`.
- R9: Chip select falls exactly once per bus read and stays low for the whole burst. `bus_rdy` is high for exactly one cycle, which is the cycle in which `spi_cs_n` has just risen. `bus_rdata` is valid in that cycle.
- R10: If `mmap_en` is cleared during a burst, the burst completes with correct data. `mmap_owner` stays high until the block is idle, then falls and hands the pins back.
- R11: `rd_setup[23:16]` (a write command byte) has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmap_en | input | 1 | 1 hands the pins to the mapped-read path |
| rd_setup | input | 32 | Burst description word |
| bus_addr | input | ADDR_W | Read byte address |
| bus_rd | input | 1 | Read request, held until ready |
| bus_rdy | output | 1 | One-cycle read completion |
| bus_rdata | output | DATA_W | Read data, little-endian byte order |
| cmd_sclk | input | 1 | Serial clock from command engine |
| cmd_cs_n | input | 1 | Chip select from command engine |
| cmd_io_o | input | 4 | Data outputs from command engine |
| cmd_io_oe | input | 4 | Output enables from command engine |
| spi_sclk | output | 1 | Serial clock pin |
| spi_cs_n | output | 1 | Chip select pin, active low |
| spi_io_o | output | 4 | Data pin outputs |
| spi_io_oe | output | 4 | Data pin output enables |
| spi_io_i | input | 4 | Data pin inputs |
| mmap_owner | output | 1 | 1 while the mapped-read path drives the pins |

## Verification
The hardest situation to reach is the enable being withdrawn while a burst is partway through. The bench clears `mmap_en` a fixed number of core cycles after chip select falls. Every cycle after that, it checks that ownership holds and that the pins stay with the burst until the word arrives. A second hard case is a request that is already waiting when ownership is granted. The bench raises `bus_rd` with the enable low, watches for a while that nothing reaches the pins, and then sets the enable without dropping the request.

// File: rtl/mfr_pkg.sv
`timescale 1ns/1ps
package mfr_pkg;

  // bit positions inside the setup word (decoded by mfr_setup_dec)
  localparam int F_OPC   = 0;
  localparam int F_ABYTE = 8;
  localparam int F_DBYTE = 10;
  localparam int F_LANE  = 12;
  localparam int F_XBIT  = 24;

  localparam int CNT_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_DUMMY,
    ST_DATA,
    ST_DONE
  } mfr_state_t;

  typedef enum logic [1:0] {
    LANE_X1,
    LANE_X2,
    LANE_X4
  } mfr_lane_t;

  typedef struct packed {
    logic [CNT_W-1:0] dummy_clks;
    logic [CNT_W-1:0] data_clks;
    mfr_lane_t        lane;
  } mfr_rdcfg_t;

endpackage

// File: rtl/mfr_setup_dec.sv
`timescale 1ns/1ps
module mfr_setup_dec
  import mfr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]      setup,
  input  logic [23:0]      addr24,
  output logic [31:0]      send_word,
  output logic [CNT_W-1:0] send_clks,
  output mfr_rdcfg_t       rdcfg
);

  localparam int CLK_X1 = DATA_W;
  localparam int CLK_X2 = DATA_W / 2;
  localparam int CLK_X4 = DATA_W / 4;

  logic [1:0]  abytes;
  logic [1:0]  dbytes;
  logic [4:0]  xbits;
  logic [7:0]  opcode;
  logic [23:0] addr_sh;

  always_comb begin
    opcode  = setup[F_OPC +: 8];
    abytes  = setup[F_ABYTE +: 2];
    dbytes  = setup[F_DBYTE +: 2];
    xbits   = setup[F_XBIT +: 5];

    // left-justify the used address bytes so they leave first
    addr_sh   = addr24 << {2'd3 - abytes, 3'b000};
    send_word = {opcode, addr_sh};
    send_clks = CNT_W'(8) + {2'b00, abytes, 3'b000};

    rdcfg.dummy_clks = {2'b00, dbytes, 3'b000} + {2'b00, xbits};
    unique case (setup[F_LANE +: 2])
      2'b01: begin
        rdcfg.lane      = LANE_X2;
        rdcfg.data_clks = CNT_W'(CLK_X2);
      end
      2'b11: begin
        rdcfg.lane      = LANE_X4;
        rdcfg.data_clks = CNT_W'(CLK_X4);
      end
      default: begin
        rdcfg.lane      = LANE_X1;
        rdcfg.data_clks = CNT_W'(CLK_X1);
      end
    endcase
  end

endmodule

// File: rtl/mfr_seq.sv
`timescale 1ns/1ps
module mfr_seq
  import mfr_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       send_word,
  input  logic [CNT_W-1:0]  send_clks,
  input  mfr_rdcfg_t        rdcfg,
  input  logic [3:0]        io_i,
  output logic              busy,
  output logic              sclk,
  output logic              cs_n,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe,
  output logic              rdy,
  output logic [DATA_W-1:0] rx_word
);

  localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  mfr_state_t        st_q, st_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic              sclk_q, sclk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [31:0]       tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  mfr_rdcfg_t        cfg_q, cfg_d;
  logic              cs_n_q, cs_n_d;
  logic              rdy_q, rdy_d;
  logic              active, tick;

  always_comb begin
    st_d   = st_q;
    hc_d   = hc_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    cfg_d  = cfg_q;
    active = (st_q == ST_SEND) || (st_q == ST_DUMMY) || (st_q == ST_DATA);
    tick   = active && (hc_q == HC_LAST);

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_SEND;
          cnt_d  = send_clks;
          tx_d   = send_word;
          cfg_d  = rdcfg;
          hc_d   = '0;
          sclk_d = 1'b0;
        end
      end
      ST_SEND, ST_DUMMY, ST_DATA: begin
        if (!tick) begin
          hc_d = hc_q + 1'b1;
        end else begin
          hc_d   = '0;
          sclk_d = ~sclk_q;
          if (!sclk_q) begin
            // rising serial edge: sample the flash
            if (st_q == ST_DATA) begin
              unique case (cfg_q.lane)
                LANE_X4: rx_d = {rx_q[DATA_W-5:0], io_i};
                LANE_X2: rx_d = {rx_q[DATA_W-3:0], io_i[1:0]};
                default: rx_d = {rx_q[DATA_W-2:0], io_i[1]};
              endcase
            end
          end else begin
            // falling serial edge: one clock finished
            tx_d = {tx_q[30:0], 1'b0};
            if (cnt_q == CNT_W'(1)) begin
              unique case (st_q)
                ST_SEND: begin
                  if (cfg_q.dummy_clks != '0) begin
                    st_d  = ST_DUMMY;
                    cnt_d = cfg_q.dummy_clks;
                  end else begin
                    st_d  = ST_DATA;
                    cnt_d = cfg_q.data_clks;
                  end
                end
                ST_DUMMY: begin
                  st_d  = ST_DATA;
                  cnt_d = cfg_q.data_clks;
                end
                default: st_d = ST_DONE;
              endcase
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    cs_n_d = !((st_d == ST_SEND) || (st_d == ST_DUMMY) || (st_d == ST_DATA));
    rdy_d  = (st_d == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hc_q   <= '0;
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      cfg_q  <= '0;
      cs_n_q <= 1'b1;
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      hc_q   <= hc_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      cfg_q  <= cfg_d;
      cs_n_q <= cs_n_d;
      rdy_q  <= rdy_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
  assign rdy     = rdy_q;
  assign rx_word = rx_q;
  assign io_o    = {3'b000, tx_q[31]};
  assign io_oe   = (st_q == ST_SEND) ? 4'b0001 : 4'b0000;

endmodule

// File: rtl/mfr_pin_mux.sv
`timescale 1ns/1ps
module mfr_pin_mux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw,
  input  logic       busy,
  input  logic       map_sclk,
  input  logic       map_cs_n,
  input  logic [3:0] map_io_o,
  input  logic [3:0] map_io_oe,
  input  logic       cmd_sclk,
  input  logic       cmd_cs_n,
  input  logic [3:0] cmd_io_o,
  input  logic [3:0] cmd_io_oe,
  output logic       pin_sclk,
  output logic       pin_cs_n,
  output logic [3:0] pin_io_o,
  output logic [3:0] pin_io_oe,
  output logic       owner
);

  logic owner_q, owner_d;

  // ownership is kept while a burst is running, even if the switch drops
  always_comb begin
    owner_d = sw | (owner_q & busy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= 1'b0;
    else        owner_q <= owner_d;
  end

  always_comb begin
    if (owner_q) begin
      pin_sclk  = map_sclk;
      pin_cs_n  = map_cs_n;
      pin_io_o  = map_io_o;
      pin_io_oe = map_io_oe;
    end else begin
      pin_sclk  = cmd_sclk;
      pin_cs_n  = cmd_cs_n;
      pin_io_o  = cmd_io_o;
      pin_io_oe = cmd_io_oe;
    end
  end

  assign owner = owner_q;

endmodule

// File: rtl/mmap_flash_reader.sv
`timescale 1ns/1ps
module mmap_flash_reader
  import mfr_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int HALF_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmap_en,
  input  logic [31:0]       rd_setup,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  output logic              bus_rdy,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cmd_sclk,
  input  logic              cmd_cs_n,
  input  logic [3:0]        cmd_io_o,
  input  logic [3:0]        cmd_io_oe,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic [3:0]        spi_io_o,
  output logic [3:0]        spi_io_oe,
  input  logic [3:0]        spi_io_i,
  output logic              mmap_owner
);

  localparam int BYTES = DATA_W / 8;

  logic [31:0]       send_word;
  logic [CNT_W-1:0]  send_clks;
  mfr_rdcfg_t        rdcfg;
  logic              start, busy;
  logic              map_sclk, map_cs_n;
  logic [3:0]        map_io_o, map_io_oe;
  logic [DATA_W-1:0] rx_word;

  mfr_setup_dec #(.DATA_W(DATA_W)) u_dec (
    .setup     (rd_setup),
    .addr24    (bus_addr[23:0]),
    .send_word (send_word),
    .send_clks (send_clks),
    .rdcfg     (rdcfg)
  );

  assign start = bus_rd && mmap_en && mmap_owner && !busy;

  mfr_seq #(.HALF_CYC(HALF_CYC), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .send_word (send_word),
    .send_clks (send_clks),
    .rdcfg     (rdcfg),
    .io_i      (spi_io_i),
    .busy      (busy),
    .sclk      (map_sclk),
    .cs_n      (map_cs_n),
    .io_o      (map_io_o),
    .io_oe     (map_io_oe),
    .rdy       (bus_rdy),
    .rx_word   (rx_word)
  );

  mfr_pin_mux u_mux (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw        (mmap_en),
    .busy      (busy),
    .map_sclk  (map_sclk),
    .map_cs_n  (map_cs_n),
    .map_io_o  (map_io_o),
    .map_io_oe (map_io_oe),
    .cmd_sclk  (cmd_sclk),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_io_o  (cmd_io_o),
    .cmd_io_oe (cmd_io_oe),
    .pin_sclk  (spi_sclk),
    .pin_cs_n  (spi_cs_n),
    .pin_io_o  (spi_io_o),
    .pin_io_oe (spi_io_oe),
    .owner     (mmap_owner)
  );

  // first received byte is the oldest, so it sits at the top of rx_word
  for (genvar g = 0; g < BYTES; g++) begin : g_swap
    assign bus_rdata[8*g +: 8] = rx_word[DATA_W-1-8*g -: 8];
  end

endmodule

// File: rtl/mfr_chk.sv
`timescale 1ns/1ps
module mfr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw,
  input logic       owner,
  input logic       busy,
  input logic       map_cs_n,
  input logic       spi_cs_n,
  input logic [3:0] spi_io_oe,
  input logic       bus_rdy
);

  // R3
  start_needs_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(map_cs_n) |-> $past(sw));

  // R9
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |=> !bus_rdy);

  // R9
  rdy_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdy |-> $rose(map_cs_n));

  // R9
  cs_needs_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !map_cs_n |-> owner);

  // R10
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner && busy) |=> owner);

  // R4
  oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner && spi_cs_n) |-> (spi_io_oe == 4'b0000));

endmodule

bind mmap_flash_reader mfr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw        (mmap_en),
  .owner     (mmap_owner),
  .busy      (busy),
  .map_cs_n  (map_cs_n),
  .spi_cs_n  (spi_cs_n),
  .spi_io_oe (spi_io_oe),
  .bus_rdy   (bus_rdy)
);

// File: tb/sim_mmap_flash_reader.sv
`timescale 1ns/1ps
module sim_mmap_flash_reader;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mmap_en;
  logic [31:0] rd_setup;
  logic [23:0] bus_addr;
  logic        bus_rd;
  logic        bus_rdy;
  logic [31:0] bus_rdata;
  logic        cmd_sclk, cmd_cs_n;
  logic [3:0]  cmd_io_o, cmd_io_oe;
  logic        spi_sclk, spi_cs_n;
  logic [3:0]  spi_io_o, spi_io_oe, spi_io_i;
  logic        mmap_owner;

  always #5 clk = ~clk;

  mmap_flash_reader u0 (
    .clk(clk), .rst_n(rst_n), .mmap_en(mmap_en), .rd_setup(rd_setup),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
    .cmd_sclk(cmd_sclk), .cmd_cs_n(cmd_cs_n), .cmd_io_o(cmd_io_o), .cmd_io_oe(cmd_io_oe),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_io_o(spi_io_o), .spi_io_oe(spi_io_oe),
    .spi_io_i(spi_io_i), .mmap_owner(mmap_owner)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model state
  int          sl_nsend, sl_ndum, sl_lanes, sl_clks, sl_csfalls, sl_oebad;
  logic [31:0] sl_stream, sl_sent;

  initial begin
    spi_io_i = 4'h0;
    forever begin
      int cnt;
      @(negedge spi_cs_n);
      sl_csfalls++;
      cnt = 0;
      while (1) begin
        int j;
        @(posedge spi_sclk or posedge spi_cs_n);
        if (spi_cs_n) break;
        if (cnt < sl_nsend) begin
          sl_sent = {sl_sent[30:0], spi_io_o[0]};
          if (spi_io_oe != 4'b0001) sl_oebad++;
        end else if (spi_io_oe != 4'b0000) begin
          sl_oebad++;
        end
        cnt++;
        sl_clks = cnt;
        @(negedge spi_sclk or posedge spi_cs_n);
        if (spi_cs_n) break;
        j = cnt - sl_nsend - sl_ndum;
        if (j >= 0 && j < 32 / sl_lanes) begin
          case (sl_lanes)
            4:       spi_io_i = sl_stream[31-4*j -: 4];
            2:       spi_io_i = {2'b00, sl_stream[31-2*j -: 2]};
            default: spi_io_i = {2'b00, sl_stream[31-j], 1'b0};
          endcase
        end else begin
          spi_io_i = 4'h0;
        end
      end
    end
  end

  // setup, address, flash stream (first byte in the top bits)
  localparam logic [95:0] VEC [7] = '{
    {32'h0012_0303, 32'h0012_3456, 32'hA1B2_C3D4},
    {32'h0012_176B, 32'h00AB_CDEF, 32'h1234_5678},
    {32'h0012_376C, 32'h0000_0104, 32'hDEAD_BEEF},
    {32'h0500_0203, 32'h00FF_8001, 32'h0F1E_2D3C},
    {32'h0000_38EB, 32'h0055_AA55, 32'h8000_0001},
    {32'h00FF_2303, 32'h0012_3456, 32'hA1B2_C3D4},
    {32'h0000_1D3B, 32'h0077_6655, 32'hC3C3_3C3C}
  };

  task automatic do_read(input logic [31:0] setup, input logic [31:0] addr,
                         input logic [31:0] stream, input int drop_after);
    int ab, db, xb, lm, lanes, nsend, ndum, waited, cs_cycles;
    bit seen, owner_ok;
    logic [63:0] exp_sent, mask;
    logic [31:0] exp_data;
    ab = int'(setup[9:8]); db = int'(setup[11:10]); xb = int'(setup[28:24]);
    lm = int'(setup[13:12]);
    lanes = (lm == 1) ? 2 : (lm == 3) ? 4 : 1;
    nsend = 8 + 8 * ab;
    ndum  = 8 * db + xb;
    exp_sent = ({56'd0, setup[7:0]} << (8 * ab)) | ({32'd0, addr} & ((64'd1 << (8 * ab)) - 1));
    mask     = (64'd1 << nsend) - 1;
    exp_data = {stream[7:0], stream[15:8], stream[23:16], stream[31:24]};
    sl_nsend = nsend; sl_ndum = ndum; sl_lanes = lanes; sl_stream = stream;
    sl_clks = 0; sl_csfalls = 0; sl_oebad = 0; sl_sent = '0;
    rd_setup = setup; bus_addr = addr[23:0]; bus_rd = 1'b1;
    seen = 0; waited = 0; cs_cycles = 0; owner_ok = 1;
    while (!seen && waited < 5000) begin
      @(negedge clk);
      waited++;
      if (!spi_cs_n) begin
        cs_cycles++;
        if (cs_cycles == drop_after) mmap_en = 1'b0;
        if (!mmap_owner) owner_ok = 0;
      end
      if (bus_rdy) seen = 1;
    end
    chk(seen, "R9 ready seen", 64'(seen), 64'd1);
    chk(bus_rdata == exp_data, "R8 data word", 64'(bus_rdata), 64'(exp_data));
    chk(spi_cs_n == 1'b1, "R9 cs high at ready", 64'(spi_cs_n), 64'd1);
    bus_rd = 1'b0;
    @(negedge clk);
    chk(bus_rdy == 1'b0, "R9 ready one cycle", 64'(bus_rdy), 64'd0);
    chk((64'(sl_sent) & mask) == exp_sent, "R4 R5 command and address",
        64'(sl_sent) & mask, exp_sent);
    chk(sl_clks == nsend + ndum + 32 / lanes, "R6 R7 clock count",
        64'(sl_clks), 64'(nsend + ndum + 32 / lanes));
    chk(sl_oebad == 0, "R4 R6 output enables", 64'(sl_oebad), 64'd0);
    chk(sl_csfalls == 1, "R9 one select per read", 64'(sl_csfalls), 64'd1);
    if (drop_after > 0)
      chk(owner_ok, "R10 owner kept during burst", 64'(owner_ok), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; mmap_en = 1'b0; rd_setup = '0; bus_addr = '0; bus_rd = 1'b0;
    cmd_sclk = 1'b0; cmd_cs_n = 1'b1; cmd_io_o = 4'h0; cmd_io_oe = 4'h0;
    sl_nsend = 8; sl_ndum = 0; sl_lanes = 1; sl_stream = '0;
    sl_clks = 0; sl_csfalls = 0; sl_oebad = 0; sl_sent = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(bus_rdy == 1'b0, "R1 ready low in reset", 64'(bus_rdy), 64'd0);
    chk(mmap_owner == 1'b0, "R1 owner low in reset", 64'(mmap_owner), 64'd0);
    chk(spi_cs_n == 1'b1, "R1 select follows command side", 64'(spi_cs_n), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mmap_owner == 1'b0 && bus_rdy == 1'b0, "R1 idle after reset",
        64'({mmap_owner, bus_rdy}), 64'd0);

    // R2 pass-through of the command engine
    cmd_sclk = 1'b1; cmd_cs_n = 1'b0; cmd_io_o = 4'hA; cmd_io_oe = 4'hF;
    @(negedge clk);
    chk({spi_sclk, spi_cs_n, spi_io_o, spi_io_oe} == {1'b1, 1'b0, 4'hA, 4'hF},
        "R2 pins follow command side", 64'({spi_sclk, spi_cs_n, spi_io_o, spi_io_oe}),
        64'({1'b1, 1'b0, 4'hA, 4'hF}));
    cmd_sclk = 1'b0; cmd_cs_n = 1'b1; cmd_io_o = 4'h0; cmd_io_oe = 4'h0;
    @(negedge clk);
    sl_csfalls = 0;

    // R3 request with the switch off stays unserved
    begin
      int rdy_cnt;
      rdy_cnt = 0;
      rd_setup = 32'h0012_0303; bus_addr = 24'h00_0010; bus_rd = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bus_rdy) rdy_cnt++;
      end
      chk(rdy_cnt == 0, "R3 no ready while switch off", 64'(rdy_cnt), 64'd0);
      chk(sl_csfalls == 0, "R3 no select while switch off", 64'(sl_csfalls), 64'd0);
    end
    mmap_en = 1'b1;
    @(negedge clk);
    chk(mmap_owner == 1'b1, "R2 owner after switch set", 64'(mmap_owner), 64'd1);
    // R3 pending request is now served
    do_read(32'h0012_0303, 32'h0000_0010, 32'h5566_7788, 0);

    // table of bursts
    for (int v = 0; v < 7; v++) begin
      do_read(VEC[v][95:64], VEC[v][63:32], VEC[v][31:0], 0);
      // R11: a changed write command byte must not disturb the burst
      if (VEC[v][87:80] != 8'h12)
        chk(bus_rdata == {VEC[v][7:0], VEC[v][15:8], VEC[v][23:16], VEC[v][31:24]},
            "R11 write byte ignored", 64'(bus_rdata), 64'(VEC[v][31:0]));
      repeat (2) @(negedge clk);
    end

    // R10 switch cleared in the middle of a quad burst
    do_read(32'h0012_376C, 32'h0012_0040, 32'h0BAD_F00D, 20);
    repeat (3) @(negedge clk);
    chk(mmap_owner == 1'b0, "R10 owner released after burst", 64'(mmap_owner), 64'd0);
    cmd_cs_n = 1'b0;
    @(negedge clk);
    chk(spi_cs_n == 1'b0, "R10 pins back to command side", 64'(spi_cs_n), 64'd0);
    cmd_cs_n = 1'b1;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule